// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits after address generation in a 32-bit load/store pipeline. Each accepted request carries four things: a six-bit major opcode, the two low address bits, the 32-bit memory word that contains the addressed bytes, and the current value of the register involved.

For a load, the unit returns the value to write back to the register. This covers byte and halfword extraction with sign or zero extension, full words, and the left and right partial-word merges. A partial-word merge combines shifted memory bytes with the register bytes that are kept.

For a store, the unit returns the merged memory word and a four-bit byte-enable mask. A misaligned halfword or word access raises a fault and writes nothing. An opcode the unit does not recognise raises an illegal flag and also writes nothing. All results are registered, so they appear one clock after the input strobe.

Top module: `lsu_lane_align`

## Requirements
- R1: `opcode_i[5:3]` = 3'b100 selects a load and 3'b101 selects a store; `opcode_i[2:0]` selects the operation. Any other class, load code 7, or store code 4, 5 or 7 sets `illegal_o`, clears `wb_en_o` and `st_be_o`, returns `reg_val_i` on `wb_data_o` and `mem_word_i` on `st_data_o`.
- R2: Load code 0 (signed byte) returns byte lane `addr_lo_i` of the memory word, sign-extended. Load code 1 (signed halfword) returns halfword lane `addr_lo_i[1]`, sign-extended. Lane n occupies bits 8n+7:8n.
- R3: Load code 4 (unsigned byte) and load code 5 (unsigned halfword) select the same lanes as R2 and zero-extend them.
- R4: Load code 3 (word) returns the memory word unchanged.
- R5: Load code 2 (left partial load) at offset k returns the memory word shifted left by 24-8k. The register bits below that shift amount fill the low end.
- R6: Load code 6 (right partial load) at offset k returns the memory word shifted right by 8k. The top 8k bits of the register fill the high end.
- R7: Store codes 0, 1 and 3 (byte, halfword, word) place register bits 7:0, 15:0 or 31:0 into the addressed lane. Only that lane is enabled in `st_be_o`. `st_data_o` takes the remaining bytes from the memory word.
- R8: Store code 2 (left partial store) at offset k keeps the top 24-8k bits of the memory word and fills the rest with the register shifted right by 24-8k. It enables lanes 0 to k.
- R9: Store code 6 (right partial store) at offset k keeps the low 8k bits of the memory word and fills the rest with the register shifted left by 8k. It enables lanes k to 3.
- R10: A halfword load or store with `addr_lo_i[0]`=1 sets `align_fault_o`, and so does a word load or store with `addr_lo_i`≠0. A faulting access has `wb_en_o` and `st_be_o` cleared and the pass-through data of R1. Partial loads and stores never fault. `align_fault_o` and `illegal_o` are never both set.
- R11: Outputs update on the first rising edge after `valid_i`=1, and `valid_o` follows `valid_i` with one cycle of delay. With `valid_i`=0 all data and flag outputs hold their values.
- R12: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 6 | Major opcode |
| addr_lo_i | input | 2 | Byte offset within the word |
| mem_word_i | input | 32 | Memory word holding the addressed bytes |
| reg_val_i | input | 32 | Current destination (load) or source (store) register value |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| wb_en_o | output | 1 | Register write-back enable |
| wb_data_o | output | 32 | Register write-back value |
| st_data_o | output | 32 | Merged memory write word |
| st_be_o | output | 4 | Per-byte store enables |
| align_fault_o | output | 1 | Misaligned access |
| illegal_o | output | 1 | Unrecognised opcode |

## Verification
Every result of this unit is due exactly one rising edge after the strobe that carries its request: write-back value and enable, store word and byte enables, and both flags. The bench drives a request on a falling edge and compares all outputs on the next falling edge, half a period after the capturing edge. After a cycle with the strobe low, it checks that the outputs still hold the earlier result although the inputs have changed.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NB     = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(NB);
  localparam int unsigned OPC_W  = 6;

  localparam logic [2:0] CLS_LOAD  = 3'b100;
  localparam logic [2:0] CLS_STORE = 3'b101;

  typedef enum logic [3:0] {
    OP_LB, OP_LH, OP_LWL, OP_LW, OP_LBU, OP_LHU, OP_LWR,
    OP_SB, OP_SH, OP_SWL, OP_SW, OP_SWR, OP_BAD
  } lsu_op_e;

  typedef struct packed {
    lsu_op_e op;
    logic    is_load;
    logic    is_store;
    logic    illegal;
    logic    fault;
  } lsu_dec_t;
endpackage

// File: rtl/lsu_op_decode.sv
module lsu_op_decode
  import lsu_align_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [OFF_W-1:0] off_i,
  output lsu_dec_t         dec_o
);
  logic [2:0] cls, sel;
  assign cls = opcode_i[5:3];
  assign sel = opcode_i[2:0];

  always_comb begin
    dec_o = '{op: OP_BAD, is_load: 1'b0, is_store: 1'b0, illegal: 1'b1, fault: 1'b0};
    if (cls == CLS_LOAD) begin
      unique case (sel)
        3'd0: dec_o.op = OP_LB;
        3'd1: dec_o.op = OP_LH;
        3'd2: dec_o.op = OP_LWL;
        3'd3: dec_o.op = OP_LW;
        3'd4: dec_o.op = OP_LBU;
        3'd5: dec_o.op = OP_LHU;
        3'd6: dec_o.op = OP_LWR;
        default: dec_o.op = OP_BAD;
      endcase
      dec_o.is_load = (dec_o.op != OP_BAD);
    end else if (cls == CLS_STORE) begin
      unique case (sel)
        3'd0: dec_o.op = OP_SB;
        3'd1: dec_o.op = OP_SH;
        3'd2: dec_o.op = OP_SWL;
        3'd3: dec_o.op = OP_SW;
        3'd6: dec_o.op = OP_SWR;
        default: dec_o.op = OP_BAD;
      endcase
      dec_o.is_store = (dec_o.op != OP_BAD);
    end
    dec_o.illegal = (dec_o.op == OP_BAD);
    unique case (dec_o.op)
      OP_LH, OP_LHU, OP_SH: dec_o.fault = off_i[0];
      OP_LW, OP_SW:         dec_o.fault = (off_i != '0);
      default:              dec_o.fault = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_align_pkg::*;
(
  input  lsu_op_e           op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] wb_o
);
  localparam int unsigned SH_W = $clog2(DATA_W) + 1;

  logic [7:0]        byte_sel;
  logic [15:0]       half_sel;
  logic [SH_W-1:0]   sh_left, sh_right;
  logic [DATA_W-1:0] low_mask, high_keep;
  logic [DATA_W-1:0] lwl_res, lwr_res;

  assign byte_sel  = mem_i[8*off_i +: 8];
  assign half_sel  = mem_i[16*off_i[OFF_W-1] +: 16];
  // left: 24 - 8k ; right: 8k
  assign sh_left   = SH_W'(8 * (NB - 1 - int'(off_i)));
  assign sh_right  = SH_W'(8 * int'(off_i));
  assign low_mask  = ~({DATA_W{1'b1}} << sh_left);
  assign high_keep = ~({DATA_W{1'b1}} >> sh_right);
  assign lwl_res   = (mem_i << sh_left) | (reg_i & low_mask);
  assign lwr_res   = (reg_i & high_keep) | (mem_i >> sh_right);

  always_comb begin
    unique case (op_i)
      OP_LB:   wb_o = {{(DATA_W-8){byte_sel[7]}}, byte_sel};
      OP_LBU:  wb_o = {{(DATA_W-8){1'b0}}, byte_sel};
      OP_LH:   wb_o = {{(DATA_W-16){half_sel[15]}}, half_sel};
      OP_LHU:  wb_o = {{(DATA_W-16){1'b0}}, half_sel};
      OP_LW:   wb_o = mem_i;
      OP_LWL:  wb_o = lwl_res;
      OP_LWR:  wb_o = lwr_res;
      default: wb_o = reg_i;
    endcase
  end
endmodule

// File: rtl/lsu_store_merge.sv
module lsu_store_merge
  import lsu_align_pkg::*;
(
  input  lsu_op_e           op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] data_o,
  output logic [NB-1:0]     be_o
);
  localparam int unsigned SH_W = $clog2(DATA_W) + 1;

  logic [SH_W-1:0]   sh_byte, sh_rev;
  logic [DATA_W-1:0] placed;
  logic [DATA_W-1:0] lane_mask;

  assign sh_byte = SH_W'(8 * int'(off_i));
  assign sh_rev  = SH_W'(8 * (NB - 1 - int'(off_i)));

  always_comb begin
    placed = '0;
    be_o   = '0;
    unique case (op_i)
      OP_SB: begin
        placed = {{(DATA_W-8){1'b0}}, reg_i[7:0]} << sh_byte;
        be_o   = NB'(1) << off_i;
      end
      OP_SH: begin
        placed = {{(DATA_W-16){1'b0}}, reg_i[15:0]} << sh_byte;
        be_o   = NB'(3) << off_i;
      end
      OP_SW: begin
        placed = reg_i;
        be_o   = '1;
      end
      OP_SWL: begin
        placed = reg_i >> sh_rev;
        be_o   = {NB{1'b1}} >> (NB - 1 - int'(off_i));
      end
      OP_SWR: begin
        placed = reg_i << sh_byte;
        be_o   = {NB{1'b1}} << off_i;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_mask[8*g +: 8] = {8{be_o[g]}};
  end

  assign data_o = (placed & lane_mask) | (mem_i & ~lane_mask);
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] mem_word_i,
  input  logic [DATA_W-1:0] reg_val_i,
  output logic              valid_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic [NB-1:0]     st_be_o,
  output logic              align_fault_o,
  output logic              illegal_o
);
  lsu_dec_t          dec;
  logic [DATA_W-1:0] ld_val, st_val;
  logic [NB-1:0]     st_mask;
  logic              ok;

  lsu_op_decode u_dec (
    .opcode_i (opcode_i),
    .off_i    (addr_lo_i),
    .dec_o    (dec)
  );

  lsu_load_fmt u_ld (
    .op_i  (dec.op),
    .off_i (addr_lo_i),
    .mem_i (mem_word_i),
    .reg_i (reg_val_i),
    .wb_o  (ld_val)
  );

  lsu_store_merge u_st (
    .op_i   (dec.op),
    .off_i  (addr_lo_i),
    .mem_i  (mem_word_i),
    .reg_i  (reg_val_i),
    .data_o (st_val),
    .be_o   (st_mask)
  );

  assign ok = !dec.fault && !dec.illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      wb_en_o       <= 1'b0;
      wb_data_o     <= '0;
      st_data_o     <= '0;
      st_be_o       <= '0;
      align_fault_o <= 1'b0;
      illegal_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        wb_en_o       <= ok && dec.is_load;
        wb_data_o     <= (ok && dec.is_load) ? ld_val : reg_val_i;
        st_be_o       <= (ok && dec.is_store) ? st_mask : '0;
        st_data_o     <= (ok && dec.is_store) ? st_val : mem_word_i;
        align_fault_o <= dec.fault;
        illegal_o     <= dec.illegal;
      end
    end
  end
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk
  import lsu_align_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [OFF_W-1:0]  addr_lo_i,
  input logic [DATA_W-1:0] mem_word_i,
  input logic              valid_o,
  input logic              wb_en_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic [NB-1:0]     st_be_o,
  input logic              align_fault_o,
  input logic              illegal_o
);
  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(align_fault_o && illegal_o));

  p_fault_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> (!wb_en_o && st_be_o == '0));

  p_illegal_no_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wb_en_o && st_be_o == '0));

  p_load_xor_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (st_be_o == '0));

  p_valid_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(wb_data_o) && $stable(st_be_o) && $stable(wb_en_o)));

  p_lwl_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == 6'b100010 && addr_lo_i == 2'd3) |=> wb_data_o == $past(mem_word_i));

  p_swl_lanes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == 6'b101010) |=> $countones(st_be_o) == int'($past(addr_lo_i)) + 1);

  p_swr_lanes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == 6'b101110) |=> $countones(st_be_o) == NB - int'($past(addr_lo_i)));
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .opcode_i      (opcode_i),
  .addr_lo_i     (addr_lo_i),
  .mem_word_i    (mem_word_i),
  .valid_o       (valid_o),
  .wb_en_o       (wb_en_o),
  .wb_data_o     (wb_data_o),
  .st_be_o       (st_be_o),
  .align_fault_o (align_fault_o),
  .illegal_o     (illegal_o)
);

// File: tb/lsu_lane_align_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_align_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [1:0]  addr_lo_i = '0;
  logic [31:0] mem_word_i = '0;
  logic [31:0] reg_val_i = '0;
  logic        valid_o, wb_en_o, align_fault_o, illegal_o;
  logic [31:0] wb_data_o, st_data_o;
  logic [3:0]  st_be_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lsu_lane_align dut_i (.*);

  function automatic logic [7:0] lane(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  task automatic model(input logic [5:0] opc, input logic [1:0] a,
                       input logic [31:0] m, input logic [31:0] r,
                       output logic e_wb_en, output logic [31:0] e_wb,
                       output logic [31:0] e_sd, output logic [3:0] e_be,
                       output logic e_flt, output logic e_ill, output string tag);
    int k;
    k = int'(a);
    e_wb_en = 0; e_wb = r; e_sd = m; e_be = 0; e_flt = 0; e_ill = 0; tag = "R1";
    if (opc[5:3] == 3'b100) begin
      case (opc[2:0])
        3'd0, 3'd4: begin
          tag = opc[2] ? "R3" : "R2";
          e_wb = {{24{~opc[2] & m[8*k+7]}}, lane(m, k)};
          e_wb_en = 1;
        end
        3'd1, 3'd5: begin
          tag = opc[2] ? "R3" : "R2";
          if (a[0]) begin e_flt = 1; tag = "R10"; end
          else begin
            e_wb = {{16{~opc[2] & m[16*a[1]+15]}}, m[16*a[1] +: 16]};
            e_wb_en = 1;
          end
        end
        3'd3: begin
          tag = "R4";
          if (a != 0) begin e_flt = 1; tag = "R10"; end
          else begin e_wb = m; e_wb_en = 1; end
        end
        3'd2: begin
          tag = "R5"; e_wb_en = 1;
          for (int j = 0; j < 4; j++)
            e_wb[8*j +: 8] = (j >= 3 - k) ? lane(m, j - (3 - k)) : lane(r, j);
        end
        3'd6: begin
          tag = "R6"; e_wb_en = 1;
          for (int j = 0; j < 4; j++)
            e_wb[8*j +: 8] = (j + k <= 3) ? lane(m, j + k) : lane(r, j);
        end
        default: e_ill = 1;
      endcase
    end else if (opc[5:3] == 3'b101) begin
      case (opc[2:0])
        3'd0: begin tag = "R7"; e_be = 4'b1 << k; e_sd[8*k +: 8] = r[7:0]; end
        3'd1: begin
          tag = "R7";
          if (a[0]) begin e_flt = 1; tag = "R10"; end
          else begin e_be = 4'b11 << k; e_sd[8*k +: 16] = r[15:0]; end
        end
        3'd3: begin
          tag = "R7";
          if (a != 0) begin e_flt = 1; tag = "R10"; end
          else begin e_be = 4'hf; e_sd = r; end
        end
        3'd2: begin
          tag = "R8";
          for (int j = 0; j <= k; j++) begin
            e_be[j] = 1; e_sd[8*j +: 8] = lane(r, j + 3 - k);
          end
        end
        3'd6: begin
          tag = "R9";
          for (int j = k; j < 4; j++) begin
            e_be[j] = 1; e_sd[8*j +: 8] = lane(r, j - k);
          end
        end
        default: e_ill = 1;
      endcase
    end else e_ill = 1;
  endtask

  task automatic run_one(input logic [5:0] opc, input logic [1:0] a,
                         input logic [31:0] m, input logic [31:0] r);
    logic ew; logic [31:0] ewb, esd; logic [3:0] ebe; logic ef, ei; string tag;
    model(opc, a, m, r, ew, ewb, esd, ebe, ef, ei, tag);
    @(negedge clk_i);
    valid_i = 1; opcode_i = opc; addr_lo_i = a; mem_word_i = m; reg_val_i = r;
    @(negedge clk_i);
    valid_i = 0;
    n_tests++;
    if ({valid_o, wb_en_o, wb_data_o, st_data_o, st_be_o, align_fault_o, illegal_o} !==
        {1'b1, ew, ewb, esd, ebe, ef, ei}) begin
      n_fail++;
      $display("FAIL %s op=%b a=%0d got v%b en%b wb=%h sd=%h be=%b f%b i%b exp en%b wb=%h sd=%h be=%b f%b i%b",
               tag, opc, a, valid_o, wb_en_o, wb_data_o, st_data_o, st_be_o, align_fault_o,
               illegal_o, ew, ewb, esd, ebe, ef, ei);
    end
  endtask

  initial begin
    logic [31:0] hold_wb, hold_sd;
    logic [3:0]  hold_be;
    logic [5:0] ops [12] = '{6'o40, 6'o41, 6'o42, 6'o43, 6'o44, 6'o45, 6'o46,
                             6'o50, 6'o51, 6'o52, 6'o53, 6'o56};
    void'($urandom(32'd20240611));
    #35;
    // R12: reset state
    n_tests++;
    if ({valid_o, wb_en_o, wb_data_o, st_data_o, st_be_o, align_fault_o, illegal_o} !== '0) begin
      n_fail++;
      $display("FAIL R12 outputs in reset got %h exp 0", {wb_data_o, st_data_o, st_be_o});
    end
    rst_ni = 1;

    // directed corners
    run_one(6'o40, 2'd3, 32'h80_22_33_44, 32'h0);        // R2 negative byte lane 3
    run_one(6'o44, 2'd3, 32'h80_22_33_44, 32'h0);        // R3
    run_one(6'o41, 2'd2, 32'h9abc_1234, 32'h0);          // R2 upper half
    run_one(6'o45, 2'd2, 32'h9abc_1234, 32'h0);          // R3
    run_one(6'o43, 2'd0, 32'hdead_beef, 32'h1);          // R4
    for (int k = 0; k < 4; k++) begin
      run_one(6'o42, 2'(k), 32'h1122_3344, 32'haabb_ccdd); // R5
      run_one(6'o46, 2'(k), 32'h1122_3344, 32'haabb_ccdd); // R6
      run_one(6'o52, 2'(k), 32'h1122_3344, 32'haabb_ccdd); // R8
      run_one(6'o56, 2'(k), 32'h1122_3344, 32'haabb_ccdd); // R9
      run_one(6'o50, 2'(k), 32'h1122_3344, 32'haabb_ccdd); // R7
    end
    run_one(6'o51, 2'd1, 32'h1, 32'h2);                  // R10 half
    run_one(6'o43, 2'd2, 32'h1, 32'h2);                  // R10 word
    run_one(6'o53, 2'd3, 32'h1, 32'h2);                  // R10
    run_one(6'o47, 2'd0, 32'h5, 32'h6);                  // R1 load code 7
    run_one(6'o54, 2'd0, 32'h5, 32'h6);                  // R1 store code 4
    run_one(6'o00, 2'd0, 32'h5, 32'h6);                  // R1 other class

    // R11: hold with strobe low
    run_one(6'o50, 2'd1, 32'h1234_5678, 32'h0000_00ab);
    hold_wb = wb_data_o; hold_sd = st_data_o; hold_be = st_be_o;
    opcode_i = 6'o43; mem_word_i = 32'hffff_ffff; reg_val_i = 32'h0;
    @(negedge clk_i);
    @(negedge clk_i);
    n_tests++;
    if (valid_o !== 0 || wb_data_o !== hold_wb || st_data_o !== hold_sd || st_be_o !== hold_be) begin
      n_fail++;
      $display("FAIL R11 hold got v%b sd=%h be=%b exp v0 sd=%h be=%b",
               valid_o, st_data_o, st_be_o, hold_sd, hold_be);
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0] o;
      o = ($urandom_range(0, 7) == 0) ? 6'($urandom) : ops[$urandom_range(0, 11)];
      run_one(o, 2'($urandom), $urandom, $urandom);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule